// File: doc/BRIEF.md
# Programmable Read-Only Memory Device Model with Mode Decode and Identifier Readout

This block is a synthesizable, clocked stand-in for a byte-wide one-time-programmable memory. It is meant for testbenches and emulation platforms that exercise programmer or boot logic. On every rising clock edge it samples an active-low chip select, an active-low output enable, the byte address and two digital flags. One flag says that the programming supply is raised. The other says that the identification voltage is present on the dedicated address pin. From these inputs it picks one operating mode, and it registers the result onto a data bus with an explicit drive-enable.

The array starts in the erased state, with every bit one. Programming is a bitwise AND of the stored byte with the input byte, so a cleared bit never comes back. A single erase input restores the whole array. An identification mode returns two fixed codes whose top bit makes the parity odd. The model also counts the program pulses each byte has received. The count of the addressed byte is always visible, so a programmer bench can check how many pulses it applied.

All outputs appear one clock after the inputs that produce them. The default array is small (2^ADDR_W bytes). Raising ADDR_W to 15 gives the full 32K x 8 organisation.

Top module: `eprom_model`

## Requirements
- R1: After reset every byte reads 8'hFF and every pulse count reads 0.
- R2: With chip select low, output enable low, supply flag low and identification flag low, the byte at `addr` is driven (`dout_en`=1) in the cycle after the inputs are sampled.
- R3: With chip select low, output enable high and the supply flag low, `dout_en` is 0.
- R4: With chip select high and the supply flag low, `dout_en` is 0 at either output-enable level.
- R5: With the supply flag high, chip select low and output enable high, the first sampled cycle of that condition stores `old & din` at `addr` and adds one to that byte's pulse count. The count saturates at 2^CNT_W-1. Holding the condition for further cycles writes nothing more and counts nothing more. Outputs float.
- R6: With the supply flag high, chip select high and output enable low, the stored byte is driven out for verify, even when the identification flag is set.
- R7: With the supply flag high and both chip select and output enable high, outputs float and the array is not written.
- R8: With the identification flag high, the supply flag low, and chip select and output enable low, `dout` is 8'hC2 when `addr[0]`=0 and 8'h10 when `addr[0]`=1.
- R9: Every identifier byte driven has odd parity over its eight bits, with bit 7 serving as the parity bit.
- R10: With the supply flag high, the identification flag has no effect. Chip select and output enable both low then leave the outputs floating, and nothing is written.
- R11: `id_addr_err` is 1 in the cycle after an identification readout in which any bit of `addr` above bit 0 is non-zero. Otherwise it is 0.
- R12: A cycle with `erase` high returns every byte to 8'hFF and every pulse count to 0. It takes priority over a program pulse in the same cycle.
- R13: Programming a byte with a one in a bit position already at zero leaves that bit at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset; also erases the array |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identification voltage present on the ID pin |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| erase | input | 1 | Restore the array to all ones |
| dout | output | 8 | Data driven out (0 when floating) |
| dout_en | output | 1 | Data bus drive-enable |
| pulse_cnt | output | CNT_W | Program pulses received by the addressed byte |
| id_addr_err | output | 1 | Upper address bits non-zero during identification |

## Verification
The assertions assume that all control inputs are clean digital levels, sampled only on the rising edge. They also assume that the identification flag is meaningful only when the supply flag is low. The bench changes every input on the falling edge and reads results one full cycle later, so each sampled combination is stable. Program pulses are always separated by an inhibit cycle, except in the one test that holds the program condition on purpose. That keeps the expected pulse counts exact.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    M_STBY, M_ODIS, M_READ, M_IDENT, M_PROG, M_VERIFY, M_INHIBIT
  } mode_e;

  // Seven payload bits of each identifier; bit 7 is computed for odd parity
  localparam logic [6:0] MFR_BASE = 7'h42;
  localparam logic [6:0] DEV_BASE = 7'h10;

  function automatic logic [BYTE_W-1:0] odd_par(input logic [6:0] base);
    return {~(^base), base};
  endfunction
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  vpp_hi,
  input  logic  id_hv,
  output mode_e mode
);
  always_comb begin
    if (vpp_hi) begin
      unique case ({ce_n, oe_n})
        2'b01:   mode = M_PROG;
        2'b10:   mode = M_VERIFY;
        2'b11:   mode = M_INHIBIT;
        default: mode = M_ODIS;   // undefined combination floats
      endcase
    end else if (ce_n) begin
      mode = M_STBY;
    end else if (oe_n) begin
      mode = M_ODIS;
    end else if (id_hv) begin
      mode = M_IDENT;
    end else begin
      mode = M_READ;
    end
  end
endmodule

// File: rtl/eprom_id_rom.sv
module eprom_id_rom
  import eprom_pkg::*;
(
  input  logic              sel_dev,
  output logic [BYTE_W-1:0] code
);
  localparam logic [BYTE_W-1:0] MFR_CODE = odd_par(MFR_BASE);
  localparam logic [BYTE_W-1:0] DEV_CODE = odd_par(DEV_BASE);

  assign code = sel_dev ? DEV_CODE : MFR_CODE;
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CNT_W-1:0]  rd_cnt
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cells [DEPTH];
  logic [CNT_W-1:0]  hits  [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || erase) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= '1;
        hits[i]  <= '0;
      end
    end else if (wr_en) begin
      cells[addr] <= cells[addr] & din;
      if (hits[addr] != '1) hits[addr] <= hits[addr] + 1'b1;
    end
  end

  assign rd_data = cells[addr];
  assign rd_cnt  = hits[addr];
endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic              erase,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic [CNT_W-1:0]  pulse_cnt,
  output logic              id_addr_err
);
  mode_e             mode;
  logic              prog_q;
  logic              wr_en;
  logic [BYTE_W-1:0] cell_byte;
  logic [BYTE_W-1:0] id_code;
  logic [CNT_W-1:0]  cell_cnt;
  logic              upper_set;

  eprom_mode_dec dec_i (
    .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi), .id_hv(id_hv), .mode(mode)
  );

  eprom_id_rom id_i (.sel_dev(addr[0]), .code(id_code));

  // A program pulse is the first sampled cycle of the program condition
  assign wr_en = (mode == M_PROG) && !prog_q;

  eprom_cell_array #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) arr_i (
    .clk(clk), .rst_n(rst_n), .erase(erase), .wr_en(wr_en),
    .addr(addr), .din(din), .rd_data(cell_byte), .rd_cnt(cell_cnt)
  );

  generate
    if (ADDR_W > 1) begin : g_upper
      assign upper_set = |addr[ADDR_W-1:1];
    end else begin : g_noupper
      assign upper_set = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q      <= 1'b0;
      dout        <= '0;
      dout_en     <= 1'b0;
      pulse_cnt   <= '0;
      id_addr_err <= 1'b0;
    end else begin
      prog_q      <= (mode == M_PROG);
      pulse_cnt   <= erase ? '0 : cell_cnt;
      id_addr_err <= (mode == M_IDENT) && upper_set;
      unique case (mode)
        M_READ, M_VERIFY: begin
          dout    <= erase ? '1 : cell_byte;
          dout_en <= 1'b1;
        end
        M_IDENT: begin
          dout    <= id_code;
          dout_en <= 1'b1;
        end
        default: begin
          dout    <= '0;
          dout_en <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/eprom_model_chk.sv
module eprom_model_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_hi,
  input logic              id_hv,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dout,
  input logic              dout_en,
  input logic              id_addr_err
);
  AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ce_n) && !$past(oe_n) && !$past(vpp_hi)) |-> dout_en); // R2

  AST_STBY_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ce_n) && !$past(vpp_hi)) |-> !dout_en); // R4

  AST_PROG_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vpp_hi) && $past(oe_n)) |-> !dout_en); // R7

  AST_ID_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(id_hv) && !$past(vpp_hi) && !$past(ce_n) && !$past(oe_n))
      |-> ($countones(dout) % 2 == 1)); // R9

  AST_ID_ERR_ONLY_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    id_addr_err |-> ($past(id_hv) && !$past(vpp_hi) && dout_en)); // R11
endmodule

bind eprom_model eprom_model_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
  .id_hv(id_hv), .addr(addr), .dout(dout), .dout_en(dout_en),
  .id_addr_err(id_addr_err)
);

// File: tb/eprom_model_tb_top.sv
`timescale 1ns/1ps
module eprom_model_tb_top;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 5;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hv = 1'b0, erase = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic dout_en;
  logic [CNT_W-1:0] pulse_cnt;
  logic id_addr_err;

  int checks = 0, fails = 0;
  logic [7:0] exp_mem [DEPTH];
  int exp_cnt [DEPTH];

  always #2.5 clk = ~clk;

  eprom_model #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hv(id_hv), .addr(addr), .din(din), .erase(erase), .dout(dout),
    .dout_en(dout_en), .pulse_cnt(pulse_cnt), .id_addr_err(id_addr_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs set at a falling edge, result visible at the next falling edge
  task automatic cyc(input logic c, input logic o, input logic v, input logic h,
                     input int a, input logic [7:0] d);
    ce_n = c; oe_n = o; vpp_hi = v; id_hv = h; addr = a[ADDR_W-1:0]; din = d;
    @(negedge clk);
  endtask

  task automatic pulse(input int a, input logic [7:0] d);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, a, d);
    chk("R5 float during program", dout_en, 0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, a, d);
    exp_mem[a] = exp_mem[a] & d;
    if (exp_cnt[a] < CMAX) exp_cnt[a]++;
  endtask

  task automatic sweep_read(input string req);
    for (int a = 0; a < DEPTH; a++) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00);
      chk(req, {dout_en, dout}, {1'b1, exp_mem[a]});
      chk(req, pulse_cnt, exp_cnt[a]);
    end
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin exp_mem[a] = 8'hFF; exp_cnt[a] = 0; end
    @(negedge clk); @(negedge clk);
    chk("R1 reset drive-enable", dout_en, 0);
    rst_n = 1'b1;
    sweep_read("R1 erased read");

    // Standby and output-disable
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 5, 0);  chk("R4 standby oe low", dout_en, 0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 5, 0);  chk("R4 standby oe high", dout_en, 0);
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 5, 0);  chk("R3 output disable", dout_en, 0);

    // First programming pass over every byte
    for (int a = 0; a < DEPTH; a++) pulse(a, 8'(a ^ 8'h5A));
    sweep_read("R2 read after program");

    // Second pass: ones over zeros must not restore bits (R13), verify mode (R6)
    for (int a = 0; a < DEPTH; a++) pulse(a, 8'(~a));
    for (int a = 0; a < DEPTH; a++) begin
      cyc(1'b1, 1'b0, 1'b1, 1'b0, a, 0);
      chk("R6 R13 verify and-ed data", {dout_en, dout}, {1'b1, exp_mem[a]});
    end
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 7, 0);
    chk("R6 verify ignores id flag", dout, exp_mem[7]);

    // Inhibit: no write, outputs float
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 9, 8'h00); chk("R7 inhibit float", dout_en, 0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 9, 0);     chk("R7 inhibit no write", dout, exp_mem[9]);

    // Held program condition counts once
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 20, 8'h0F);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 20, 8'h00);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 20, 8'h00);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 20, 0);
    exp_mem[20] = exp_mem[20] & 8'h0F; exp_cnt[20]++;
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 20, 0);
    chk("R5 held program data", dout, exp_mem[20]);
    chk("R5 held program count", pulse_cnt, exp_cnt[20]);

    // Count saturation
    for (int i = 0; i < 35; i++) pulse(3, 8'hFF);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 3, 0);
    chk("R5 count saturates", pulse_cnt, CMAX);

    // Identification
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 0, 0);
    chk("R8 manufacturer code", {dout_en, dout}, {1'b1, 8'hC2});
    chk("R9 parity mfr", ^dout, 1);
    chk("R11 no error clean addr", id_addr_err, 0);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1, 0);
    chk("R8 device code", {dout_en, dout}, {1'b1, 8'h10});
    chk("R9 parity dev", ^dout, 1);
    for (int a = 2; a < DEPTH; a += 37) begin
      cyc(1'b0, 1'b0, 1'b0, 1'b1, a, 0);
      chk("R11 upper bits error", id_addr_err, 1);
      chk("R8 code still by bit0", dout, (a % 2) ? 8'h10 : 8'hC2);
    end
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 2, 0);
    chk("R11 error clears outside ident", id_addr_err, 0);

    // Supply raised: id flag ignored, CE/OE both low floats, no write
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 0, 8'h00);
    chk("R10 id ignored with supply", dout_en, 0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 0, 0);
    chk("R10 no write", {dout, 3'b0, pulse_cnt}, {exp_mem[0], 3'b0, CNT_W'(exp_cnt[0])});

    // Erase with a program pulse in the same cycle: erase wins
    erase = 1'b1;
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 4, 8'h00);
    erase = 1'b0;
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 4, 0);
    for (int a = 0; a < DEPTH; a++) begin exp_mem[a] = 8'hFF; exp_cnt[a] = 0; end
    sweep_read("R12 erase restores");

    report();
  end
endmodule